// File: doc/BRIEF.md
# Cache Flush Sequencer

The block runs an externally requested flush of a small internal cache. A request arrives on an active-low, asynchronous pin. It is brought into the clock domain by a chain of synchronising flops and turned into a single start event. The sequencer then steps through the cache lines and reads each line's modified flag through a line-state port.

In write-back mode it raises a write-back request for every modified line and waits for a done handshake before it moves on. When the last line has been handled it invalidates the whole cache in one cycle and then issues two flush-acknowledge special cycles, which carry a fixed code. In write-through mode it skips the scan and the acknowledge cycles, so invalidation is the only step.

Two static inputs are sampled during reset:

- The mode strap sets write-back or write-through operation.
- The flush pin, if it is held low at the last clock edge before reset is released, puts the block into a three-state test mode. The pad logic uses this mode to float the outputs, and the sequencer ignores all flush requests while it lasts.

Top module: `cflush_seq`

## Requirements
- R1: While `rst` is high and after it is released with no request pending, `busy`, `wb_req`, `inv_all` and `sc_req` are low and `sc_code` is 0.
- R2: `flush_n` is asynchronous and active low and passes through two synchronising flops. A low level lasting one clock starts exactly one flush sequence. A low level held for many clocks also starts only one.
- R3: In write-back mode (`wb_mode` high at reset), each line whose `line_dirty` input is high while it is addressed receives exactly one write-back request. Requests are made in ascending `line_idx` order, and clean lines receive none.
- R4: `inv_all` is high for exactly one cycle per sequence. That cycle comes after the last write-back of the sequence has completed.
- R5: In write-back mode, `sc_req` is high for exactly two consecutive cycles, starting in the cycle right after `inv_all`. During those cycles `sc_code` equals `FLUSH_CODE` (default 4'h5). At all other times `sc_code` is 0.
- R6: In write-through mode (`wb_mode` low at reset), a sequence raises `inv_all` only. It raises no `wb_req` and no `sc_req`, whatever the line states are.
- R7: In write-back mode, each line is addressed for exactly one scan cycle. A sequence therefore has `LINES` cycles of scanning before `inv_all`, not counting the write-back wait cycles.
- R8: A flush request that arrives while a sequence is running is latched. It is serviced by one further complete sequence after the current one ends. Several such requests collapse into one.
- R9: If `flush_n` is low at the last rising clock edge with `rst` high, `test_mode` is high until the next reset, and flush requests are ignored (`busy` and `inv_all` stay low). If `flush_n` is high at that edge, `test_mode` is low.
- R10: `wb_req` and `line_idx` hold steady until `wb_done` is seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; the strap inputs are sampled while it is high |
| flush_n | input | 1 | Asynchronous flush request, active low |
| wb_mode | input | 1 | Mode strap: 1 = write-back, 0 = write-through |
| line_idx | output | IDX_W | Index of the line currently addressed |
| line_dirty | input | 1 | Modified flag of the line at `line_idx` |
| wb_req | output | 1 | Write-back request for line `line_idx`, held until done |
| wb_done | input | 1 | Write-back of the requested line has completed |
| inv_all | output | 1 | One-cycle strobe: invalidate every line |
| sc_req | output | 1 | Special-cycle request (flush acknowledge) |
| sc_code | output | CODE_W | Special-cycle code, `FLUSH_CODE` while `sc_req` is high, else 0 |
| busy | output | 1 | A flush sequence is in progress |
| test_mode | output | 1 | Three-state test mode selected at reset |

## Verification
The two functions that can fall in the same cycle are the acceptance of a fresh flush request and the running of a sequence that has not yet finished. In particular, a new edge can be latched while the scan or the acknowledge cycles are still under way. This is provoked by pulsing `flush_n` twice more in the middle of a write-back run that has one dirty line. The run is judged by counting, over the whole window, exactly two `inv_all` strobes, four `sc_req` cycles and one write-back. That shows the mid-run requests were neither lost nor serviced twice.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN,
      ST_WB,
      ST_INV,
      ST_ACK1,
      ST_ACK2
   } cfs_state_e;
endpackage

// File: rtl/cfs_sync.sv
// Synchronises the asynchronous active-low flush pin and emits one pulse per falling edge.
module cfs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_n,
   output logic req_pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfs_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b1;
            else     q <= async_n;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b1;
            else     q <= g_stage[g-1].q;
         end
      end
   end

   logic sync_n;
   logic prev_n;
   assign sync_n = g_stage[STAGES-1].q;

   always_ff @(posedge clk) begin
      if (rst) prev_n <= 1'b1;
      else     prev_n <= sync_n;
   end

   assign req_pulse = prev_n & ~sync_n;
endmodule

// File: rtl/cfs_strap.sv
// Captures the static mode strap and the test-mode strap while reset is high.
module cfs_strap (
   input  logic clk,
   input  logic rst,
   input  logic flush_n,
   input  logic wb_mode,
   output logic test_mode,
   output logic wb_sel
);
   logic tm_q;
   logic wb_q;

   // The value held after reset falls is the one seen at the last edge with rst high.
   always_ff @(posedge clk) begin
      if (rst) begin
         tm_q <= ~flush_n;
         wb_q <= wb_mode;
      end
   end

   assign test_mode = tm_q;
   assign wb_sel    = wb_q;
endmodule

// File: rtl/cfs_fsm.sv
module cfs_fsm
   import cfs_pkg::*;
#(
   parameter int LINES  = 16,
   parameter int CODE_W = 4,
   parameter logic [CODE_W-1:0] FLUSH_CODE = 4'h5,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_req,
   input  logic              enable,
   input  logic              wb_sel,
   input  logic              line_dirty,
   input  logic              wb_done,
   output logic [IDX_W-1:0]  line_idx,
   output logic              wb_req,
   output logic              inv_all,
   output logic              sc_req,
   output logic [CODE_W-1:0] sc_code,
   output logic              busy
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

   cfs_state_e       st;
   logic [IDX_W-1:0] idx;
   logic             pend;

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= ST_IDLE;
         idx  <= '0;
         pend <= 1'b0;
      end else begin
         // A fresh request outranks the acceptance of an older one.
         if (start_req && enable)        pend <= 1'b1;
         else if (st == ST_IDLE && pend) pend <= 1'b0;

         unique case (st)
            ST_IDLE: begin
               if (pend) begin
                  idx <= '0;
                  st  <= wb_sel ? ST_SCAN : ST_INV;
               end
            end
            ST_SCAN: begin
               if (line_dirty)             st  <= ST_WB;
               else if (idx == LAST_IDX)   st  <= ST_INV;
               else                        idx <= idx + IDX_W'(1);
            end
            ST_WB: begin
               if (wb_done) begin
                  if (idx == LAST_IDX) begin
                     st <= ST_INV;
                  end else begin
                     idx <= idx + IDX_W'(1);
                     st  <= ST_SCAN;
                  end
               end
            end
            ST_INV:  st <= wb_sel ? ST_ACK1 : ST_IDLE;
            ST_ACK1: st <= ST_ACK2;
            ST_ACK2: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign line_idx = idx;
   assign wb_req   = (st == ST_WB);
   assign inv_all  = (st == ST_INV);
   assign sc_req   = (st == ST_ACK1) || (st == ST_ACK2);
   assign sc_code  = sc_req ? FLUSH_CODE : '0;
   assign busy     = (st != ST_IDLE);
endmodule

// File: rtl/cflush_seq.sv
module cflush_seq #(
   parameter int LINES       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int CODE_W      = 4,
   parameter logic [CODE_W-1:0] FLUSH_CODE = 4'h5,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              flush_n,
   input  logic              wb_mode,
   output logic [IDX_W-1:0]  line_idx,
   input  logic              line_dirty,
   output logic              wb_req,
   input  logic              wb_done,
   output logic              inv_all,
   output logic              sc_req,
   output logic [CODE_W-1:0] sc_code,
   output logic              busy,
   output logic              test_mode
);
   if (LINES < 2) begin : g_bad_lines
      $error("cflush_seq: LINES must be at least 2");
   end
   if (CODE_W < 1) begin : g_bad_code
      $error("cflush_seq: CODE_W must be at least 1");
   end

   logic start_req;
   logic wb_sel;

   cfs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .async_n   (flush_n),
      .req_pulse (start_req)
   );

   cfs_strap u_strap (
      .clk       (clk),
      .rst       (rst),
      .flush_n   (flush_n),
      .wb_mode   (wb_mode),
      .test_mode (test_mode),
      .wb_sel    (wb_sel)
   );

   cfs_fsm #(
      .LINES      (LINES),
      .CODE_W     (CODE_W),
      .FLUSH_CODE (FLUSH_CODE)
   ) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .start_req  (start_req),
      .enable     (~test_mode),
      .wb_sel     (wb_sel),
      .line_dirty (line_dirty),
      .wb_done    (wb_done),
      .line_idx   (line_idx),
      .wb_req     (wb_req),
      .inv_all    (inv_all),
      .sc_req     (sc_req),
      .sc_code    (sc_code),
      .busy       (busy)
   );
endmodule

// File: rtl/cflush_chk.sv
module cflush_chk #(
   parameter int IDX_W  = 4,
   parameter int CODE_W = 4,
   parameter logic [CODE_W-1:0] FLUSH_CODE = 4'h5
) (
   input logic              clk,
   input logic              rst,
   input logic              busy,
   input logic              test_mode,
   input logic              wb_sel,
   input logic              wb_req,
   input logic              wb_done,
   input logic [IDX_W-1:0]  line_idx,
   input logic              inv_all,
   input logic              sc_req,
   input logic [CODE_W-1:0] sc_code
);
   // R4
   inv_single_chk: assert property (@(posedge clk) disable iff (rst)
      inv_all |=> !inv_all);

   // R5
   ack_follows_inv_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sc_req) |-> $past(inv_all));

   // R5
   ack_pair_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sc_req) |=> sc_req);

   // R5
   ack_stop_chk: assert property (@(posedge clk) disable iff (rst)
      (sc_req && $past(sc_req)) |=> !sc_req);

   // R5
   ack_code_chk: assert property (@(posedge clk) disable iff (rst)
      sc_req |-> (sc_code == FLUSH_CODE));

   // R6
   wt_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (inv_all && !wb_sel) |=> !sc_req);

   // R6
   wt_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
      !wb_sel |-> !wb_req);

   // R10
   wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wb_req && !wb_done) |=> (wb_req && $stable(line_idx)));

   // R9
   tm_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      test_mode |-> !busy);
endmodule

bind cflush_seq cflush_chk #(
   .IDX_W      (IDX_W),
   .CODE_W     (CODE_W),
   .FLUSH_CODE (FLUSH_CODE)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .busy      (busy),
   .test_mode (test_mode),
   .wb_sel    (wb_sel),
   .wb_req    (wb_req),
   .wb_done   (wb_done),
   .line_idx  (line_idx),
   .inv_all   (inv_all),
   .sc_req    (sc_req),
   .sc_code   (sc_code)
);

// File: tb/test_cflush_seq.sv
module test_cflush_seq;
   localparam int CLK_PERIOD = 10;
   localparam int LINES      = 16;
   localparam int IDX_W      = $clog2(LINES);
   localparam logic [3:0] FCODE = 4'h5;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             flush_n = 1'b1;
   logic             wb_mode = 1'b1;
   logic [IDX_W-1:0] line_idx;
   logic             line_dirty;
   logic             wb_req;
   logic             wb_done = 1'b0;
   logic             inv_all;
   logic             sc_req;
   logic [3:0]       sc_code;
   logic             busy;
   logic             test_mode;

   logic [LINES-1:0] dirty_mem = '0;
   assign line_dirty = dirty_mem[line_idx];

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   // results gathered by run_collect
   int wb_log[32];
   int wb_n, inv_n, sc_n, sc_bad, scan_cyc, order_bad, started;

   always #(CLK_PERIOD/2) clk = ~clk;

   cflush_seq i_cflush_seq (
      .clk        (clk),
      .rst        (rst),
      .flush_n    (flush_n),
      .wb_mode    (wb_mode),
      .line_idx   (line_idx),
      .line_dirty (line_dirty),
      .wb_req     (wb_req),
      .wb_done    (wb_done),
      .inv_all    (inv_all),
      .sc_req     (sc_req),
      .sc_code    (sc_code),
      .busy       (busy),
      .test_mode  (test_mode)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic fl, input logic mode);
      @(negedge clk);
      rst = 1'b1; flush_n = fl; wb_mode = mode; wb_done = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0; flush_n = 1'b1;
   endtask

   // Pulses flush_n low for low_len clocks, optionally pulses twice more mid-run,
   // answers write-back requests after two cycles and records what happens.
   task automatic run_collect(input int low_len, input bit extra);
      int wait_c = 0;
      int idle   = 0;
      wb_n = 0; inv_n = 0; sc_n = 0; sc_bad = 0; scan_cyc = 0; order_bad = 0; started = 0;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (busy) started = 1;
         if (inv_all) begin
            inv_n++;
            dirty_mem = '0;
         end
         if (sc_req) begin
            sc_n++;
            if (sc_code != FCODE) sc_bad++;
            if (inv_n == 0) order_bad++;
         end else if (sc_code != 4'h0) begin
            sc_bad++;
         end
         if (wb_req && inv_n > 0) order_bad++;
         if (busy && !wb_req && !inv_all && !sc_req && inv_n == 0) scan_cyc++;
         if (wb_done) begin
            wb_done = 1'b0;
         end else if (wb_req) begin
            if (wait_c == 1) begin
               wb_done = 1'b1;
               if (wb_n < 32) wb_log[wb_n] = int'(line_idx);
               wb_n++;
               dirty_mem[line_idx] = 1'b0;
               wait_c = 0;
            end else begin
               wait_c++;
            end
         end
         flush_n = !((k < low_len) || (extra && (k == 8 || k == 11)));
         if (!busy && k > low_len + 6) idle++;
         else idle = 0;
         if (idle >= 8) break;
      end
   endtask

   task automatic t_reset_state;
      do_reset(1'b1, 1'b1);
      @(negedge clk);
      chk(busy == 1'b0 && wb_req == 1'b0, "R1 busy/wb_req", int'({busy, wb_req}), 0);
      chk(inv_all == 1'b0 && sc_req == 1'b0 && sc_code == 4'h0, "R1 inv/sc", int'({inv_all, sc_req}), 0);
      chk(test_mode == 1'b0, "R9 test_mode low with flush high", int'(test_mode), 0);
   endtask

   task automatic t_wb_dirty;
      do_reset(1'b1, 1'b1);
      dirty_mem = 16'b1000_0000_0010_0101;
      run_collect(1, 1'b0);
      chk(started == 1, "R2 one-clock pulse starts flush", started, 1);
      chk(wb_n == 4, "R3 write-back count", wb_n, 4);
      chk(wb_log[0] == 0 && wb_log[1] == 2 && wb_log[2] == 5 && wb_log[3] == 15,
          "R3 ascending order (last)", wb_log[3], 15);
      chk(inv_n == 1, "R4 single invalidate", inv_n, 1);
      chk(order_bad == 0, "R4 invalidate after write-backs", order_bad, 0);
      chk(sc_n == 2, "R5 two acknowledge cycles", sc_n, 2);
      chk(sc_bad == 0, "R5 acknowledge code", sc_bad, 0);
      chk(scan_cyc == LINES, "R7 scan cycles", scan_cyc, LINES);
   endtask

   task automatic t_wb_clean;
      do_reset(1'b1, 1'b1);
      dirty_mem = '0;
      run_collect(1, 1'b0);
      chk(wb_n == 0, "R3 no write-back for clean lines", wb_n, 0);
      chk(scan_cyc == LINES, "R7 clean scan length", scan_cyc, LINES);
      chk(sc_n == 2 && inv_n == 1, "R5 acks on clean flush", sc_n, 2);
   endtask

   task automatic t_wt;
      do_reset(1'b1, 1'b0);
      dirty_mem = '1;
      run_collect(1, 1'b0);
      chk(inv_n == 1, "R6 write-through invalidates", inv_n, 1);
      chk(wb_n == 0, "R6 write-through no write-back", wb_n, 0);
      chk(sc_n == 0, "R6 write-through no special cycle", sc_n, 0);
   endtask

   task automatic t_hold;
      do_reset(1'b1, 1'b1);
      dirty_mem = '0;
      run_collect(10, 1'b0);
      chk(inv_n == 1, "R2 held-low flush runs once", inv_n, 1);
   endtask

   task automatic t_overlap;
      do_reset(1'b1, 1'b1);
      dirty_mem = 16'h0010;
      run_collect(1, 1'b1);
      chk(inv_n == 2, "R8 latched request gives one more sequence", inv_n, 2);
      chk(sc_n == 4, "R8 acknowledge cycles over two sequences", sc_n, 4);
      chk(wb_n == 1, "R8 write-backs over two sequences", wb_n, 1);
   endtask

   task automatic t_test_mode;
      do_reset(1'b0, 1'b1);
      @(negedge clk);
      chk(test_mode == 1'b1, "R9 test_mode entered", int'(test_mode), 1);
      dirty_mem = '1;
      run_collect(1, 1'b0);
      chk(started == 0 && inv_n == 0, "R9 flush ignored in test mode", inv_n + started, 0);
      do_reset(1'b1, 1'b1);
      @(negedge clk);
      chk(test_mode == 1'b0, "R9 test_mode cleared by reset", int'(test_mode), 0);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin
      t_reset_state();
      t_wb_dirty();
      t_wb_clean();
      t_wt();
      t_hold();
      t_overlap();
      t_test_mode();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule